// File: doc/BRIEF.md
# Network Board Control and Parity Capture

This block is the host-facing control and status logic of a network coprocessor board. The host reaches it through a small 16-bit register window with three registers: a control/status word, a parity control word and a parity low-address word. The control/status word drives the board reset, the transceiver loopback/on-air select, the attention strobe to the coprocessor, the two interrupt enables, the auxiliary memory bus enable, the RAM size select and four high address bits. It also reports a coprocessor interrupt flag and a parity-error flag. The enabled flags are merged into one host interrupt line.

When the board's memory reports a parity error, the block records the failing address, the requester that caused the error and the byte lane that failed. It keeps that first record and ignores later errors until the host acknowledges. Two small state machines hold the sequencing. The attention machine has states ATT_IDLE, ATT_FIRE and ATT_HELD, with these transitions: IDLE to FIRE when the attention bit is written to 1, FIRE to HELD (or to IDLE if the bit is written back to 0), and HELD to IDLE when the bit is written to 0. The parity machine has states PAR_ARMED and PAR_HELD, with these transitions: ARMED to HELD on an error pulse, and HELD to ARMED on an acknowledge write.

Register reads are combinational from the selected index. Writes take effect at the clock edge where `wr_en` is sampled high.

Top module: `nbc_board_ctl`

## Requirements
- R1: After reset the status word (index 0) reads 0x8000, so only board reset is asserted. Indices 1 and 2 read 0, `host_irq` and `attn_pulse` are 0, and all other control outputs are 0.
- R2: A write to index 0 loads bit 15 (board reset), bit 14 (on air), bit 12 (coprocessor interrupt enable), bit 11 (parity interrupt enable), bit 5 (auxiliary bus enable), bit 4 (256 KB RAM select) and bits 3:0 (high address). The same bits read back and drive the matching outputs. Writes to bits 10, 9, 8, 7 and 6 have no effect, and bits 10, 7 and 6 always read 0.
- R3: Writing bit 13 (attention) from 0 to 1 raises `attn_pulse` for exactly the one cycle after the write edge. Writing 1 while the bit is already 1 gives no pulse. Bit 13 reads back as written.
- R4: A `cop_irq_pulse` sets status bit 8 on the next edge. The flag is cleared at the edge that ends an attention pulse, and a new pulse in that same cycle takes priority.
- R5: `host_irq` is high exactly when (bit 8 and bit 12) or (bit 9 and bit 11) are set.
- R6: The first `par_err_pulse` while the parity flag is clear sets status bit 9 and latches the error inputs. Index 1 then reads source in bit 7, lane in bit 6 and address bits 19:16 in bits 3:0. Index 2 reads address bits 15:0.
- R7: While the parity flag is set, later error pulses change neither the flag nor the captured values.
- R8: A write to index 1 with bit 8 = 1 clears the parity flag and re-arms capture. Captured values stay readable after the acknowledge. A write with bit 8 = 0 has no effect, and bit 8 always reads 0.
- R9: Writes to index 2 have no effect, and index 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_idx | input | 2 | Register index for read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data of the selected register |
| cop_irq_pulse | input | 1 | Coprocessor interrupt request pulse |
| par_err_pulse | input | 1 | Parity error pulse from the memory |
| par_err_addr | input | 20 | Address of the failing access |
| par_err_src | input | 1 | Requester of the failing access |
| par_err_lane | input | 1 | Byte lane that failed |
| board_reset | output | 1 | Board reset to the coprocessor |
| on_air | output | 1 | Transceiver out of loopback |
| attn_pulse | output | 1 | One-cycle attention strobe |
| aux_bus_en | output | 1 | Auxiliary memory bus enable |
| ram_256k | output | 1 | 256 KB RAM device select |
| hi_addr | output | 4 | High address bits 20:17 |
| host_irq | output | 1 | Merged host interrupt |

## Verification
On every cycle, the assertions check that an attention pulse lasts a single cycle, that only a 0-to-1 write of the attention bit starts one, and that a coprocessor pulse sets its flag. They also check that a first parity error is latched with its address, that a held record stays stable until acknowledged, and that an acknowledge clears the flag. The bench scenarios show the register readback layout, that write-ignored bits and registers stay unchanged, the exact interrupt merging under each enable setting, and re-capture of a fresh error after acknowledge.

// File: rtl/nbc_pkg.sv
package nbc_pkg;

    // Status word bit positions (host software decodes these)
    localparam int STAT_W     = 16;
    localparam int B_BRD_RST  = 15;
    localparam int B_ON_AIR   = 14;
    localparam int B_ATTN     = 13;
    localparam int B_COP_IE   = 12;
    localparam int B_PAR_IE   = 11;
    localparam int B_PAR_FLAG = 9;
    localparam int B_COP_FLAG = 8;
    localparam int B_AUX_EN   = 5;
    localparam int B_RAM_SEL  = 4;

    // Parity control word bit positions
    localparam int B_ACK      = 8;
    localparam int B_SRC      = 7;
    localparam int B_LANE     = 6;

    // Register indices
    localparam int IDX_STATUS = 0;
    localparam int IDX_PCTL   = 1;
    localparam int IDX_PADDR  = 2;

    typedef enum logic [1:0] {
        ATT_IDLE = 2'd0,
        ATT_FIRE = 2'd1,
        ATT_HELD = 2'd2
    } attn_state_e;

    typedef enum logic {
        PAR_ARMED = 1'b0,
        PAR_HELD  = 1'b1
    } par_state_e;

    typedef struct packed {
        logic brd_rst;
        logic on_air;
        logic cop_ie;
        logic par_ie;
        logic aux_en;
        logic ram_sel;
    } ctl_bits_t;

endpackage

// File: rtl/nbc_ctl_reg.sv
module nbc_ctl_reg
    import nbc_pkg::*;
#(
    parameter int HI_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_stat,
    input  logic [STAT_W-1:0]   wr_data,
    output ctl_bits_t           ctl,
    output logic [HI_W-1:0]     hi_addr
);

    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[B_ATTN], wr_data[10:6]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl     <= '{brd_rst: 1'b1, default: 1'b0};
            hi_addr <= '0;
        end else if (wr_stat) begin
            ctl.brd_rst <= wr_data[B_BRD_RST];
            ctl.on_air  <= wr_data[B_ON_AIR];
            ctl.cop_ie  <= wr_data[B_COP_IE];
            ctl.par_ie  <= wr_data[B_PAR_IE];
            ctl.aux_en  <= wr_data[B_AUX_EN];
            ctl.ram_sel <= wr_data[B_RAM_SEL];
            hi_addr     <= wr_data[HI_W-1:0];
        end
    end

endmodule

// File: rtl/nbc_attn_fsm.sv
module nbc_attn_fsm
    import nbc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_stat,
    input  logic wr_bit,
    output logic attn_pulse,
    output logic attn_level
);

    attn_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ATT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ATT_IDLE: if (wr_stat && wr_bit)  state_d = ATT_FIRE;
            ATT_FIRE: if (wr_stat && !wr_bit) state_d = ATT_IDLE;
                      else                    state_d = ATT_HELD;
            ATT_HELD: if (wr_stat && !wr_bit) state_d = ATT_IDLE;
            default:                          state_d = ATT_IDLE;
        endcase
    end

    always_comb begin
        attn_pulse = (state_q == ATT_FIRE);
        attn_level = (state_q != ATT_IDLE);
    end

endmodule

// File: rtl/nbc_par_capture.sv
module nbc_par_capture
    import nbc_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_pulse,
    input  logic [ADDR_W-1:0] err_addr,
    input  logic              err_src,
    input  logic              err_lane,
    input  logic              ack,
    output logic              flag,
    output logic [ADDR_W-1:0] cap_addr,
    output logic              cap_src,
    output logic              cap_lane
);

    par_state_e state_q, state_d;
    logic       capture;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PAR_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            PAR_ARMED: if (err_pulse) begin
                state_d = PAR_HELD;
                capture = 1'b1;
            end
            PAR_HELD:  if (ack) state_d = PAR_ARMED;
            default:   state_d = PAR_ARMED;
        endcase
    end

    always_comb flag = (state_q == PAR_HELD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_src  <= 1'b0;
            cap_lane <= 1'b0;
        end else if (capture) begin
            cap_addr <= err_addr;
            cap_src  <= err_src;
            cap_lane <= err_lane;
        end
    end

endmodule

// File: rtl/nbc_irq_unit.sv
module nbc_irq_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic cop_irq_pulse,
    input  logic attn_pulse,
    input  logic cop_ie,
    input  logic par_ie,
    input  logic par_flag,
    output logic cop_flag,
    output logic host_irq
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cop_flag <= 1'b0;
        else if (cop_irq_pulse) cop_flag <= 1'b1;
        else if (attn_pulse)    cop_flag <= 1'b0;
    end

    always_comb host_irq = (cop_flag & cop_ie) | (par_flag & par_ie);

endmodule

// File: rtl/nbc_board_ctl.sv
module nbc_board_ctl
    import nbc_pkg::*;
#(
    parameter int IDX_W = 2,
    parameter int LO_W  = 16,
    parameter int HI_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IDX_W-1:0]     reg_idx,
    input  logic                 wr_en,
    input  logic [15:0]          wr_data,
    output logic [15:0]          rd_data,
    input  logic                 cop_irq_pulse,
    input  logic                 par_err_pulse,
    input  logic [LO_W+HI_W-1:0] par_err_addr,
    input  logic                 par_err_src,
    input  logic                 par_err_lane,
    output logic                 board_reset,
    output logic                 on_air,
    output logic                 attn_pulse,
    output logic                 aux_bus_en,
    output logic                 ram_256k,
    output logic [HI_W-1:0]      hi_addr,
    output logic                 host_irq
);

    localparam int ADDR_W = LO_W + HI_W;

    logic              wr_stat, wr_pctl, ack;
    ctl_bits_t         ctl;
    logic              attn_level;
    logic              cop_flag, par_flag;
    logic [ADDR_W-1:0] cap_addr;
    logic              cap_src, cap_lane;

    assign wr_stat = wr_en && (reg_idx == IDX_W'(IDX_STATUS));
    assign wr_pctl = wr_en && (reg_idx == IDX_W'(IDX_PCTL));
    assign ack     = wr_pctl && wr_data[B_ACK];

    nbc_ctl_reg #(.HI_W(HI_W)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stat (wr_stat),
        .wr_data (wr_data),
        .ctl     (ctl),
        .hi_addr (hi_addr)
    );

    nbc_attn_fsm u_attn (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stat    (wr_stat),
        .wr_bit     (wr_data[B_ATTN]),
        .attn_pulse (attn_pulse),
        .attn_level (attn_level)
    );

    nbc_par_capture #(.ADDR_W(ADDR_W)) u_par (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_pulse (par_err_pulse),
        .err_addr  (par_err_addr),
        .err_src   (par_err_src),
        .err_lane  (par_err_lane),
        .ack       (ack),
        .flag      (par_flag),
        .cap_addr  (cap_addr),
        .cap_src   (cap_src),
        .cap_lane  (cap_lane)
    );

    nbc_irq_unit u_irq (
        .clk           (clk),
        .rst_n         (rst_n),
        .cop_irq_pulse (cop_irq_pulse),
        .attn_pulse    (attn_pulse),
        .cop_ie        (ctl.cop_ie),
        .par_ie        (ctl.par_ie),
        .par_flag      (par_flag),
        .cop_flag      (cop_flag),
        .host_irq      (host_irq)
    );

    assign board_reset = ctl.brd_rst;
    assign on_air      = ctl.on_air;
    assign aux_bus_en  = ctl.aux_en;
    assign ram_256k    = ctl.ram_sel;

    always_comb begin
        rd_data = '0;
        unique case (reg_idx)
            IDX_W'(IDX_STATUS): begin
                rd_data[B_BRD_RST]  = ctl.brd_rst;
                rd_data[B_ON_AIR]   = ctl.on_air;
                rd_data[B_ATTN]     = attn_level;
                rd_data[B_COP_IE]   = ctl.cop_ie;
                rd_data[B_PAR_IE]   = ctl.par_ie;
                rd_data[B_PAR_FLAG] = par_flag;
                rd_data[B_COP_FLAG] = cop_flag;
                rd_data[B_AUX_EN]   = ctl.aux_en;
                rd_data[B_RAM_SEL]  = ctl.ram_sel;
                rd_data[HI_W-1:0]   = hi_addr;
            end
            IDX_W'(IDX_PCTL): begin
                rd_data[B_SRC]      = cap_src;
                rd_data[B_LANE]     = cap_lane;
                rd_data[HI_W-1:0]   = cap_addr[ADDR_W-1:LO_W];
            end
            IDX_W'(IDX_PADDR): begin
                rd_data[LO_W-1:0]   = cap_addr[LO_W-1:0];
            end
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/nbc_board_ctl_chk.sv
module nbc_board_ctl_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_stat,
    input logic              wr_attn,
    input logic              attn_pulse,
    input logic              attn_level,
    input logic              cop_irq_pulse,
    input logic              cop_flag,
    input logic              par_err_pulse,
    input logic [ADDR_W-1:0] par_err_addr,
    input logic              par_flag,
    input logic              par_ie,
    input logic              ack,
    input logic [ADDR_W-1:0] cap_addr,
    input logic              host_irq
);

    // R3
    p_attn_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        attn_pulse |=> !attn_pulse);
    p_attn_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && wr_attn && !attn_level) |=> attn_pulse);
    p_attn_no_repeat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && attn_level) |=> !attn_pulse);

    // R4
    p_cop_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cop_irq_pulse |=> cop_flag);

    // R5
    p_par_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (par_err_pulse && !par_flag && par_ie && !wr_stat) |=> host_irq);

    // R6
    p_first_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (par_err_pulse && !par_flag) |=> (par_flag && cap_addr == $past(par_err_addr)));

    // R7
    p_capture_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (par_flag && !ack) |=> (par_flag && $stable(cap_addr)));

    // R8
    p_ack_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (par_flag && ack) |=> !par_flag);

endmodule

bind nbc_board_ctl nbc_board_ctl_chk #(.ADDR_W(LO_W + HI_W)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_stat       (wr_stat),
    .wr_attn       (wr_data[13]),
    .attn_pulse    (attn_pulse),
    .attn_level    (attn_level),
    .cop_irq_pulse (cop_irq_pulse),
    .cop_flag      (cop_flag),
    .par_err_pulse (par_err_pulse),
    .par_err_addr  (par_err_addr),
    .par_flag      (par_flag),
    .par_ie        (ctl.par_ie),
    .ack           (ack),
    .cap_addr      (cap_addr),
    .host_irq      (host_irq)
);

// File: tb/test_nbc_board_ctl.sv
`timescale 1ns/1ps
module test_nbc_board_ctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_idx = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        cop_irq_pulse = 1'b0;
    logic        par_err_pulse = 1'b0;
    logic [19:0] par_err_addr = '0;
    logic        par_err_src = 1'b0;
    logic        par_err_lane = 1'b0;
    logic        board_reset, on_air, attn_pulse, aux_bus_en, ram_256k, host_irq;
    logic [3:0]  hi_addr;

    always #2.5 clk = ~clk;

    nbc_board_ctl i_nbc_board_ctl (
        .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .cop_irq_pulse(cop_irq_pulse),
        .par_err_pulse(par_err_pulse), .par_err_addr(par_err_addr),
        .par_err_src(par_err_src), .par_err_lane(par_err_lane),
        .board_reset(board_reset), .on_air(on_air), .attn_pulse(attn_pulse),
        .aux_bus_en(aux_bus_en), .ram_256k(ram_256k), .hi_addr(hi_addr),
        .host_irq(host_irq)
    );

    typedef struct {
        int          due;
        logic [15:0] rd;
        logic [9:0]  outs;
        string       tag;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [9:0] mk(input logic irq, input logic attn, input logic brst,
                                      input logic air, input logic aux, input logic ram,
                                      input logic [3:0] hi);
        return {irq, attn, brst, air, aux, ram, hi};
    endfunction

    // driver: select register, push expected item for this cycle, advance
    task automatic chk(input logic [1:0] idx, input logic [15:0] rd,
                       input logic [9:0] outs, input string tag);
        item_t it;
        reg_idx = idx;
        it.due = cyc; it.rd = rd; it.outs = outs; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] idx, input logic [15:0] d);
        reg_idx = idx; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic cop_pulse();
        cop_irq_pulse = 1'b1;
        @(negedge clk);
        cop_irq_pulse = 1'b0;
    endtask

    task automatic par_err(input logic [19:0] a, input logic s, input logic l);
        par_err_pulse = 1'b1; par_err_addr = a; par_err_src = s; par_err_lane = l;
        @(negedge clk);
        par_err_pulse = 1'b0;
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0 && q[0].due == cyc) begin
                item_t it;
                logic [9:0] act;
                it = q.pop_front();
                act = {host_irq, attn_pulse, board_reset, on_air, aux_bus_en, ram_256k, hi_addr};
                checks++;
                if (rd_data !== it.rd || act !== it.outs) begin
                    errors++;
                    $display("FAIL %s rd=%h outs=%b expected rd=%h outs=%b",
                             it.tag, rd_data, act, it.rd, it.outs);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    localparam logic [9:0] O_A = 10'b0001111010; // on_air, aux, ram, hi=A

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(2'd0, 16'h8000, mk(0,0,1,0,0,0,4'h0), "R1 status");
        chk(2'd1, 16'h0000, mk(0,0,1,0,0,0,4'h0), "R1 pctl");
        chk(2'd2, 16'h0000, mk(0,0,1,0,0,0,4'h0), "R1 paddr");

        // R2 status fields, ignored bits
        wr(2'd0, 16'h5FFA);
        chk(2'd0, 16'h583A, O_A, "R2 write/readback");

        // R3 attention pulse
        wr(2'd0, 16'h783A);
        chk(2'd0, 16'h783A, O_A | 10'b0100000000, "R3 pulse");
        chk(2'd0, 16'h783A, O_A, "R3 pulse ends");
        wr(2'd0, 16'h783A);
        chk(2'd0, 16'h783A, O_A, "R3 no repeat");

        // R4/R5 coprocessor flag
        cop_pulse();
        chk(2'd0, 16'h793A, O_A | 10'b1000000000, "R4 cop flag set R5 irq");
        wr(2'd0, 16'h583A);
        chk(2'd0, 16'h593A, O_A | 10'b1000000000, "R4 flag kept");
        wr(2'd0, 16'h783A);
        chk(2'd0, 16'h793A, O_A | 10'b1100000000, "R4 pulse with flag");
        chk(2'd0, 16'h783A, O_A, "R4 flag cleared");

        // R5 disabled cop interrupt
        wr(2'd0, 16'h683A);
        cop_pulse();
        chk(2'd0, 16'h693A, O_A, "R5 cop masked");

        // R6 parity capture
        par_err(20'hB1234, 1'b1, 1'b0);
        chk(2'd0, 16'h6B3A, O_A | 10'b1000000000, "R6 flag R5 par irq");
        chk(2'd1, 16'h008B, O_A | 10'b1000000000, "R6 pctl");
        chk(2'd2, 16'h1234, O_A | 10'b1000000000, "R6 paddr");

        // R7 later errors ignored
        par_err(20'h55678, 1'b0, 1'b1);
        chk(2'd1, 16'h008B, O_A | 10'b1000000000, "R7 pctl held");
        chk(2'd2, 16'h1234, O_A | 10'b1000000000, "R7 paddr held");

        // R8 acknowledge
        wr(2'd1, 16'h0000);
        chk(2'd0, 16'h6B3A, O_A | 10'b1000000000, "R8 no ack");
        wr(2'd1, 16'h0100);
        chk(2'd0, 16'h693A, O_A, "R8 ack clears");
        chk(2'd1, 16'h008B, O_A, "R8 capture kept");

        // R6/R7 re-armed capture
        par_err(20'h55678, 1'b0, 1'b1);
        chk(2'd1, 16'h0045, O_A | 10'b1000000000, "R7 rearmed pctl");
        chk(2'd2, 16'h5678, O_A | 10'b1000000000, "R7 rearmed paddr");

        // R9 index 2 read-only, index 3 zero
        wr(2'd2, 16'hFFFF);
        chk(2'd2, 16'h5678, O_A | 10'b1000000000, "R9 paddr write ignored");
        chk(2'd3, 16'h0000, O_A | 10'b1000000000, "R9 index 3");

        // R2 board reset bit, enables off
        wr(2'd0, 16'h8000);
        chk(2'd0, 16'h8300, mk(0,0,1,0,0,0,4'h0), "R2 board reset R5 masked");

        @(negedge clk);
        @(negedge clk);
        if (q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard left %0d items", q.size());
        end
        finish_run();
    end

endmodule